// File: doc/BRIEF.md
# Real-time clock register file with host access

This block holds the 128-byte address space of a real-time clock. The space has ten time, calendar and alarm bytes, four control and status bytes, and general-purpose storage. A host reads and writes the space through a simple synchronous port, and the block applies a fixed write-protection mask to each byte. Two status registers and two single bits cannot be changed by the host. The time-keeping logic outside this block writes them through a separate update port. That port can set any selected bits of any byte, and when both ports hit the same byte in one cycle it wins for the bits it selects.

An active-low reset input cuts off the host port while it is low. It also clears the periodic and alarm event flags, the square-wave enable and the update-ended interrupt enable. Everything else is left as it was: time, alarm, storage and the other control bits. Tying the reset input high therefore leaves the control state untouched through a power failure. The interrupt request pin is open-drain and is modelled by an output-enable signal. The enable is active while any event flag is set and reset is high. A host read of the status register clears all of its flags.

Address layout:
- 0x00 to 0x09: seconds, seconds alarm, minutes, minutes alarm, hours, hours alarm, weekday, day of month, month, year.
- 0x0A to 0x0D: control registers A, B, C and D.
- 0x0E to 0x7F: storage.

Top module: `rtc_regfile`

## Requirements
- R1: A host write to address 0x01 to 0x09, 0x0B or 0x0E to 0x7F replaces all eight bits of that byte, and a later host read returns the written value.
- R2: A host write to the seconds byte (0x00) or register A (0x0A) changes bits 6:0 only, and bit 7 keeps its previous value.
- R3: Host writes to register C (0x0C) and register D (0x0D) leave both registers unchanged.
- R4: Read data is registered. `host_rdata` shows the byte addressed in a cycle with `host_re` high during the next cycle. It is zero in the cycle after a cycle without `host_re`.
- R5: While `rst_n` is low, host writes have no effect and `host_rdata` is zero in the following cycle.
- R6: Each clock edge with `rst_n` low clears register C bit 6 (periodic flag), register C bit 5 (alarm flag), register B bit 4 (update-ended enable) and register B bit 3 (square-wave enable). All other bits of all bytes, including register C bit 4, keep their values.
- R7: Register C reads as bit 6 periodic flag, bit 5 alarm flag, bit 4 update-ended flag, bit 7 the OR of bits 6:4, and bits 3:0 zero.
- R8: A host read of register C returns the value before clearing. All flags in register C are zero from the next cycle, unless the update port sets a flag in the same cycle, in which case that flag stays set.
- R9: The update port writes the bits selected by `upd_mask` at `upd_addr` in any byte, including read-only bits. It also acts while `rst_n` is low, except that the clears of R6 take precedence. When the host port writes the same byte in the same cycle, the update port supplies its masked bits and the host supplies the remaining writable bits.
- R10: `irq_oe` is high exactly when `rst_n` is high and register C bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also blocks the host port |
| host_addr | input | 7 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | 8 | Registered host read data |
| upd_addr | input | 7 | Update port byte address |
| upd_data | input | 8 | Update port data |
| upd_mask | input | 8 | Update port bit select |
| upd_we | input | 1 | Update port write strobe |
| irq_oe | output | 1 | Interrupt pin output enable (pin drives low when high) |

## Verification
The assertions check on every cycle the following:
- A host-only write leaves seconds bit 7, register A bit 7 and register D unchanged.
- Reset clears its four bits and zeroes the read data.
- A host read of register C with no competing update leaves every flag clear.

Only the bench scenarios can show that stored values come back correctly across the whole address space, under two data patterns. The same applies to the bit merge when both ports hit one byte, to a flag set by an update racing a clearing read, and to storage and unaffected control bits surviving a reset episode.

// File: rtl/rtc_regfile_pkg.sv
// Package: shared constants, the write-request type and helpers for the
// RTC register file. Assumes a 7-bit byte address and 8-bit data.
package rtc_regfile_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int NUM_BYTES = 1 << ADDR_W;
    localparam int FLAG_N    = 3;

    localparam logic [ADDR_W-1:0] ADR_SEC = 7'h00;
    localparam logic [ADDR_W-1:0] ADR_A   = 7'h0A;
    localparam logic [ADDR_W-1:0] ADR_B   = 7'h0B;
    localparam logic [ADDR_W-1:0] ADR_C   = 7'h0C;
    localparam logic [ADDR_W-1:0] ADR_D   = 7'h0D;

    // bit positions
    localparam int RO_BIT    = 7;   // protected bit in seconds and register A
    localparam int C_ANY     = 7;
    localparam int C_PER     = 6;
    localparam int C_ALM     = 5;
    localparam int C_UPD     = 4;
    localparam int B_UIE     = 4;
    localparam int B_SQW     = 3;

    typedef struct packed {
        logic              sel;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] mask;
    } byte_wr_t;

    // host-writable bits of each address
    function automatic logic [DATA_W-1:0] host_mask(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] m;
        m = '1;
        if (a == ADR_SEC || a == ADR_A) m[RO_BIT] = 1'b0;
        if (a == ADR_C || a == ADR_D)   m = '0;
        return m;
    endfunction

    // replace the selected bits of a byte
    function automatic logic [DATA_W-1:0] merge_bits(input logic [DATA_W-1:0] old,
                                                     input logic [DATA_W-1:0] nd,
                                                     input logic [DATA_W-1:0] m);
        return (old & ~m) | (nd & m);
    endfunction

    // true when a write request targets the given address
    function automatic logic hits(input byte_wr_t w, input logic [ADDR_W-1:0] a);
        return w.sel && (w.addr == a);
    endfunction

    // true for the four control and status addresses
    function automatic logic is_ctrl(input int a);
        return (a >= int'(ADR_A)) && (a <= int'(ADR_D));
    endfunction

endpackage

// File: rtl/rtc_wr_gate.sv
// Write gate: turns the raw host and update strobes into byte write
// requests. Applies the per-byte host protection mask and blocks the host
// while reset is low. Assumes single-cycle strobes sampled by the consumer.
module rtc_wr_gate
    import rtc_regfile_pkg::*;
(
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_data,
    input  logic [DATA_W-1:0] upd_mask,
    input  logic              upd_we,
    output byte_wr_t          host_wr,
    output byte_wr_t          upd_wr
);

    // host request: protection mask applied, dropped during reset
    always_comb begin
        host_wr.sel  = host_we && rst_n;
        host_wr.addr = host_addr;
        host_wr.data = host_wdata;
        host_wr.mask = host_mask(host_addr);
    end

    // update request: passed through, works during reset as well
    always_comb begin
        upd_wr.sel  = upd_we;
        upd_wr.addr = upd_addr;
        upd_wr.data = upd_data;
        upd_wr.mask = upd_mask;
    end

endmodule

// File: rtl/rtc_byte_bank.sv
// Byte bank: flip-flop storage for the time, calendar, alarm and storage
// bytes. The control addresses are skipped and read back as zero here.
// Holds no reset: contents survive the reset input by design.
module rtc_byte_bank
    import rtc_regfile_pkg::*;
#(
    parameter int N_BYTES = NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  byte_wr_t          host_wr,
    input  byte_wr_t          upd_wr,
    output logic [DATA_W-1:0] bytes_q [N_BYTES]
);

    for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
        if (is_ctrl(i)) begin : g_hole
            assign bytes_q[i] = '0;
        end else begin : g_cell
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
            logic [DATA_W-1:0] q;
            logic [DATA_W-1:0] nxt;
            // next value: host bits first, then update bits on top
            always_comb begin
                nxt = q;
                if (hits(host_wr, MY_ADDR)) nxt = merge_bits(nxt, host_wr.data, host_wr.mask);
                if (hits(upd_wr, MY_ADDR))  nxt = merge_bits(nxt, upd_wr.data, upd_wr.mask);
            end
            // byte register, loaded on either port hitting it
            always_ff @(posedge clk) begin
                if (hits(host_wr, MY_ADDR) || hits(upd_wr, MY_ADDR)) q <= nxt;
            end
            assign bytes_q[i] = q;
        end
    end

    // R2
    sec_ro_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hits(host_wr, ADR_SEC) && !hits(upd_wr, ADR_SEC)) |=> $stable(bytes_q[ADR_SEC][RO_BIT]));

endmodule

// File: rtl/rtc_ctrl_regs.sv
// Control registers A to D. Register C keeps only its three event flags
// and derives the summary bit. Reset clears selected flag and enable bits
// synchronously and leaves every other bit untouched. Drives the
// interrupt pin enable.
module rtc_ctrl_regs
    import rtc_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  byte_wr_t          host_wr,
    input  byte_wr_t          upd_wr,
    input  logic              rd_clear,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic [DATA_W-1:0] reg_c,
    output logic [DATA_W-1:0] reg_d,
    output logic              irq_oe
);

    logic [DATA_W-1:0] a_q, b_q, d_q;
    logic [DATA_W-1:0] a_nxt, b_nxt, d_nxt;
    logic [FLAG_N-1:0] flag_q, flag_nxt;   // {periodic, alarm, update-ended}

    // register A: host sees bits 6:0, update may touch all bits
    always_comb begin
        a_nxt = a_q;
        if (hits(host_wr, ADR_A)) a_nxt = merge_bits(a_nxt, host_wr.data, host_wr.mask);
        if (hits(upd_wr, ADR_A))  a_nxt = merge_bits(a_nxt, upd_wr.data, upd_wr.mask);
    end

    // register B: fully writable, two enables cleared while reset is low
    always_comb begin
        b_nxt = b_q;
        if (hits(host_wr, ADR_B)) b_nxt = merge_bits(b_nxt, host_wr.data, host_wr.mask);
        if (hits(upd_wr, ADR_B))  b_nxt = merge_bits(b_nxt, upd_wr.data, upd_wr.mask);
        if (!rst_n) begin
            b_nxt[B_UIE] = 1'b0;
            b_nxt[B_SQW] = 1'b0;
        end
    end

    // register C flags: read clears, update sets, reset clears two flags
    always_comb begin
        flag_nxt = rd_clear ? '0 : flag_q;
        if (hits(upd_wr, ADR_C))
            flag_nxt = (flag_nxt & ~upd_wr.mask[C_PER:C_UPD]) |
                       (upd_wr.data[C_PER:C_UPD] & upd_wr.mask[C_PER:C_UPD]);
        if (!rst_n) begin
            flag_nxt[C_PER-C_UPD] = 1'b0;
            flag_nxt[C_ALM-C_UPD] = 1'b0;
        end
    end

    // register D: written by the update port only
    always_comb begin
        d_nxt = d_q;
        if (hits(upd_wr, ADR_D)) d_nxt = merge_bits(d_nxt, upd_wr.data, upd_wr.mask);
    end

    // state registers, reset handled inside the next-state logic above
    always_ff @(posedge clk) begin
        a_q    <= a_nxt;
        b_q    <= b_nxt;
        flag_q <= flag_nxt;
        d_q    <= d_nxt;
    end

    // register views and interrupt pin enable
    assign reg_a  = a_q;
    assign reg_b  = b_q;
    assign reg_c  = {|flag_q, flag_q, 4'b0000};
    assign reg_d  = d_q;
    assign irq_oe = rst_n && reg_c[C_ANY];

    // R3
    ro_regd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hits(host_wr, ADR_D) && !hits(upd_wr, ADR_D)) |=> $stable(reg_d));

    // R2
    rega_ro_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hits(host_wr, ADR_A) && !hits(upd_wr, ADR_A)) |=> $stable(reg_a[RO_BIT]));

    // R6
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (reg_b[B_UIE] == 1'b0 && reg_b[B_SQW] == 1'b0 &&
                    reg_c[C_PER] == 1'b0 && reg_c[C_ALM] == 1'b0));

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !hits(upd_wr, ADR_C)) |=> (reg_c == '0));

endmodule

// File: rtl/rtc_regfile.sv
// Top of the RTC register file: write gating, byte bank, control registers
// and the registered host read path. A read of register C requests the
// flag clear. Read data is zero when no read was issued or reset is low.
module rtc_regfile
    import rtc_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_we,
    input  logic              host_re,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_data,
    input  logic [DATA_W-1:0] upd_mask,
    input  logic              upd_we,
    output logic              irq_oe
);

    byte_wr_t          host_wr, upd_wr;
    logic [DATA_W-1:0] bank_q [NUM_BYTES];
    logic [DATA_W-1:0] reg_a, reg_b, reg_c, reg_d;
    logic [DATA_W-1:0] rd_val;
    logic              rd_clear;

    rtc_wr_gate u_gate (
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_we    (host_we),
        .upd_addr   (upd_addr),
        .upd_data   (upd_data),
        .upd_mask   (upd_mask),
        .upd_we     (upd_we),
        .host_wr    (host_wr),
        .upd_wr     (upd_wr)
    );

    rtc_byte_bank #(.N_BYTES(NUM_BYTES)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_wr (host_wr),
        .upd_wr  (upd_wr),
        .bytes_q (bank_q)
    );

    rtc_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (host_wr),
        .upd_wr   (upd_wr),
        .rd_clear (rd_clear),
        .reg_a    (reg_a),
        .reg_b    (reg_b),
        .reg_c    (reg_c),
        .reg_d    (reg_d),
        .irq_oe   (irq_oe)
    );

    // flag clear request from an accepted read of register C
    assign rd_clear = rst_n && host_re && (host_addr == ADR_C);

    // read multiplexer over the bank and the control registers
    always_comb begin
        case (host_addr)
            ADR_A:   rd_val = reg_a;
            ADR_B:   rd_val = reg_b;
            ADR_C:   rd_val = reg_c;
            ADR_D:   rd_val = reg_d;
            default: rd_val = bank_q[host_addr];
        endcase
    end

    // registered read data, zero in reset and when idle
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_re) host_rdata <= rd_val;
        else              host_rdata <= '0;
    end

    // R5
    rst_rdata_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (host_rdata == '0));

endmodule

// File: tb/rtc_regfile_test.sv
// Bench: sweeps the whole address space with two patterns. Exercises the
// reset side effects, port collisions and the read-clear race against a
// byte model built from the requirements.
module rtc_regfile_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_we = 1'b0;
    logic       host_re = 1'b0;
    logic [7:0] host_rdata;
    logic [6:0] upd_addr = '0;
    logic [7:0] upd_data = '0;
    logic [7:0] upd_mask = '0;
    logic       upd_we = 1'b0;
    logic       irq_oe;

    logic [7:0] exp_mem [128];
    logic [2:0] exp_flags;          // {periodic, alarm, update-ended}
    int         n_checks = 0;
    int         n_fails  = 0;
    bit         done = 1'b0;

    rtc_regfile uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
        .upd_addr(upd_addr), .upd_data(upd_data), .upd_mask(upd_mask),
        .upd_we(upd_we), .irq_oe(irq_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] wmask(int a);
        if (a == 0 || a == 10) return 8'h7F;
        if (a == 12 || a == 13) return 8'h00;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] exp_byte(int a);
        if (a == 12) return {|exp_flags, exp_flags, 4'b0000};
        return exp_mem[a];
    endfunction

    function automatic string req_of(int a);
        if (a == 0 || a == 10) return "R2";
        if (a == 12 || a == 13) return "R3";
        return "R1";
    endfunction

    function automatic logic [7:0] pat1(int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] pat2(int a);
        return ~pat1(a) ^ 8'(a);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, expv);
        end
    endtask

    // model side of a host write
    task automatic model_host(int a, logic [7:0] d);
        if (rst_n && a != 12)
            exp_mem[a] = (exp_mem[a] & ~wmask(a)) | (d & wmask(a));
    endtask

    // model side of an update write, including the reset clears
    task automatic model_upd(int a, logic [7:0] d, logic [7:0] m);
        if (a == 12) exp_flags = (exp_flags & ~m[6:4]) | (d[6:4] & m[6:4]);
        else         exp_mem[a] = (exp_mem[a] & ~m) | (d & m);
        if (!rst_n) begin
            exp_flags[2:1] = 2'b00;
            exp_mem[11][4] = 1'b0;
            exp_mem[11][3] = 1'b0;
        end
    endtask

    task automatic host_write(int a, logic [7:0] d);
        @(negedge clk);
        host_addr = 7'(a); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        model_host(a, d);
    endtask

    task automatic upd_write(int a, logic [7:0] d, logic [7:0] m);
        @(negedge clk);
        upd_addr = 7'(a); upd_data = d; upd_mask = m; upd_we = 1'b1;
        @(negedge clk);
        upd_we = 1'b0;
        model_upd(a, d, m);
    endtask

    task automatic read_check(int a, string req);
        logic [7:0] expv;
        expv = rst_n ? exp_byte(a) : 8'h00;
        @(negedge clk);
        host_addr = 7'(a); host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0;
        if (rst_n && a == 12) exp_flags = 3'b000;
        check(req, host_rdata, expv);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
        exp_flags = 3'b000;

        // reset phase: outputs quiet, update port still active
        repeat (3) @(negedge clk);
        check("R10 irq_oe in reset", {7'b0, irq_oe}, 8'h00);
        check("R5 rdata in reset", host_rdata, 8'h00);
        upd_write(0, 8'h00, 8'h80);
        upd_write(10, 8'hFF, 8'hFF);
        upd_write(11, 8'hFF, 8'hFF);
        upd_write(12, 8'h70, 8'hFF);
        upd_write(13, 8'h80, 8'hFF);
        read_check(11, "R5 read in reset");

        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R10 irq_oe with update flag", {7'b0, irq_oe}, 8'h01);
        read_check(11, "R6 reg B enables cleared");
        check("R6 B value", exp_mem[11], 8'hE7);
        read_check(12, "R7 R6 reg C update flag kept");
        read_check(12, "R8 reg C cleared after read");
        #1;
        check("R10 irq_oe after clear", {7'b0, irq_oe}, 8'h00);
        @(negedge clk);
        check("R4 idle rdata", host_rdata, 8'h00);

        // sweeps over the whole space
        for (int a = 0; a < 128; a++) host_write(a, pat1(a));
        for (int a = 0; a < 128; a++) read_check(a, req_of(a));
        for (int a = 0; a < 128; a++) host_write(a, pat2(a));
        for (int a = 0; a < 128; a++) read_check(a, req_of(a));

        // collision on seconds: update owns its masked bits
        @(negedge clk);
        host_addr = 7'h00; host_wdata = 8'h00; host_we = 1'b1;
        upd_addr = 7'h00; upd_data = 8'hA5; upd_mask = 8'h8F; upd_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; upd_we = 1'b0;
        model_host(0, 8'h00); model_upd(0, 8'hA5, 8'h8F);
        read_check(0, "R9 collision seconds");
        check("R9 seconds value", exp_mem[0], 8'h85);

        // collision on register B
        @(negedge clk);
        host_addr = 7'h0B; host_wdata = 8'h00; host_we = 1'b1;
        upd_addr = 7'h0B; upd_data = 8'hFF; upd_mask = 8'h0F; upd_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; upd_we = 1'b0;
        model_host(11, 8'h00); model_upd(11, 8'hFF, 8'h0F);
        read_check(11, "R9 collision reg B");

        // alarm flag raises the interrupt
        upd_write(12, 8'h20, 8'h20);
        #1;
        check("R10 irq_oe on alarm flag", {7'b0, irq_oe}, 8'h01);

        // read of C races an update that sets the periodic flag
        @(negedge clk);
        host_addr = 7'h0C; host_re = 1'b1;
        upd_addr = 7'h0C; upd_data = 8'h40; upd_mask = 8'h40; upd_we = 1'b1;
        @(negedge clk);
        host_re = 1'b0; upd_we = 1'b0;
        check("R8 race read value", host_rdata, 8'hA0);
        exp_flags = 3'b100;
        read_check(12, "R8 raced flag kept");
        read_check(12, "R8 cleared after second read");

        // update port writes read-only bits
        upd_write(0, 8'h80, 8'h80);
        read_check(0, "R9 seconds bit 7 by update");
        upd_write(13, 8'h3C, 8'hFF);
        read_check(13, "R9 reg D by update");
        host_write(13, 8'hC3);
        read_check(13, "R3 reg D host write ignored");

        // second reset episode with everything set
        upd_write(12, 8'h70, 8'h70);
        host_write(11, 8'hFF);
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R10 irq_oe released in reset", {7'b0, irq_oe}, 8'h00);
        model_upd(13, exp_mem[13], 8'h00);
        host_write(32, 8'h11);
        read_check(32, "R5 read zero in reset");
        @(negedge clk); rst_n = 1'b1;
        read_check(12, "R6 only update-ended flag survives");
        read_check(11, "R6 reg B after reset");
        read_check(32, "R5 write in reset ignored");
        for (int a = 0; a < 11; a++) read_check(a, "R6 time bytes and A kept");
        read_check(13, "R6 reg D kept");
        read_check(127, "R6 storage kept");

        finish_run();
    end

endmodule